// File: doc/BRIEF.md
# Pairable Nibble Register Bank

This block stores the general registers of a very small processor: four registers of four bits each. The ALU gets two operands through two read ports. Each port has its own 2-bit index, so the ALU can read any two registers in one cycle. A single write port updates one register on a clock edge when its enable is high.

For memory accesses that go through a pointer, the same four registers act as two 8-bit pointers. The low pair puts register 1 above register 0. The high pair puts register 3 above register 2. A one-bit pointer select picks which pair drives the 8-bit address output. There are no separate pointer registers: a nibble write changes the pointer view at the same moment it changes the operand view.

Top module: `nib_regbank`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all four registers to 0, so both read ports and the pointer output read 0 after it.
- R2: Read port A outputs the register selected by the 2-bit index sel_a (0..3 selects r0..r3), combinationally.
- R3: Read port B outputs the register selected by sel_b independently of sel_a, including when both indices are equal.
- R4: With wr_en high at a rising edge, the 4-bit wr_data is stored into the register numbered wr_idx, and no other register changes.
- R5: With wr_en low at a rising edge, no register changes whatever wr_idx and wr_data are.
- R6: The pointer output is {r1,r0} when ptr_sel is 0 and {r3,r2} when ptr_sel is 1, with the odd register in bits 7:4.
- R7: A read in the cycle of a write to the same register returns the old value; the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 2 | Destination register index |
| wr_data | input | 4 | Data to write |
| sel_a | input | 2 | Read port A index |
| sel_b | input | 2 | Read port B index |
| ptr_sel | input | 1 | Pointer pair select |
| rd_a | output | 4 | Operand A |
| rd_b | output | 4 | Operand B |
| ptr_addr | output | 8 | Selected 8-bit pointer |

## Verification
A corrupted register, or a write that went to the wrong index, shows on every output that reads that register. It is visible once the bench selects that register on a read port or selects its pair on the pointer output. The reference model is compared on every clock, and the read indices sweep all registers. A stray write is therefore caught within a few cycles of the edge that caused it. Swapped nibbles in a pair show up on the first pointer read that has unequal halves.

// File: rtl/nib_regbank.sv
module nib_regbank #(
  parameter int NW = 4,
  parameter int NR = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [$clog2(NR)-1:0] wr_idx,
  input  logic [NW-1:0]         wr_data,
  input  logic [$clog2(NR)-1:0] sel_a,
  input  logic [$clog2(NR)-1:0] sel_b,
  input  logic                  ptr_sel,
  output logic [NW-1:0]         rd_a,
  output logic [NW-1:0]         rd_b,
  output logic [2*NW-1:0]       ptr_addr
);
  logic [NW-1:0] regs [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_a     = regs[sel_a];
  assign rd_b     = regs[sel_b];
  assign ptr_addr = ptr_sel ? {regs[3], regs[2]} : {regs[1], regs[0]};
endmodule

module nib_regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_idx,
  input logic [3:0] wr_data,
  input logic [1:0] sel_a,
  input logic [1:0] sel_b,
  input logic       ptr_sel,
  input logic [3:0] rd_a,
  input logic [3:0] rd_b,
  input logic [7:0] ptr_addr
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_a == 4'h0 && rd_b == 4'h0 && ptr_addr == 8'h00));
  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_a == wr_idx) |=> ($past(sel_a) != sel_a || rd_a == $past(wr_data)));
  // R3
  same_index_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_a == sel_b) |-> (rd_a == rd_b));
  // R5
  hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && $stable(ptr_sel) && !$past(rst)) |=> (!$stable(ptr_sel) || $stable(ptr_addr)));
  // R6
  pair_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!ptr_sel && sel_a == 2'd0 && sel_b == 2'd1) |-> (ptr_addr == {rd_b, rd_a}));
  // R6
  pair_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_sel && sel_a == 2'd2 && sel_b == 2'd3) |-> (ptr_addr == {rd_b, rd_a}));
endmodule

bind nib_regbank nib_regbank_chk u_chk (.*);

// File: tb/nib_regbank_tb.sv
module nib_regbank_tb_top;
  logic clk = 0;
  logic rst, wr_en, ptr_sel;
  logic [1:0] wr_idx, sel_a, sel_b;
  logic [3:0] wr_data, rd_a, rd_b;
  logic [7:0] ptr_addr;
  int compared = 0, mismatched = 0;
  int model [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  nib_regbank dut_i (.*);

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk({req, " R2 rd_a"}, rd_a, model[sel_a]);
    chk({req, " R3 rd_b"}, rd_b, model[sel_b]);
    chk({req, " R6 ptr"}, ptr_addr,
        ptr_sel ? (model[3] * 16 + model[2]) : (model[1] * 16 + model[0]));
  endtask

  task automatic step(bit we, int wi, int wd, int a, int b, bit p, string req);
    wr_en = we; wr_idx = 2'(wi); wr_data = 4'(wd);
    sel_a = 2'(a); sel_b = 2'(b); ptr_sel = p;
    #1;
    compare_all(req);
    if (we && (a == wi)) chk("R7 old value", rd_a, model[wi]);
    @(posedge clk);
    if (we) model[wi] = wd & 15;
    #1;
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_idx = 0; wr_data = 0; sel_a = 0; sel_b = 0; ptr_sel = 0;
    for (int i = 0; i < 4; i++) model[i] = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    for (int s = 0; s < 4; s++) begin
      sel_a = 2'(s); sel_b = 2'(3 - s); ptr_sel = s[0]; #1;
      chk("R1 reset a", rd_a, 0); chk("R1 reset b", rd_b, 0); chk("R1 reset ptr", ptr_addr, 0);
    end
    step(1, 0, 4'h5, 0, 1, 0, "R4 w0");
    step(1, 1, 4'hA, 1, 0, 0, "R4 w1");
    step(1, 2, 4'h3, 2, 3, 1, "R4 w2");
    step(1, 3, 4'hC, 3, 2, 1, "R4 w3");
    for (int i = 0; i < 16; i++) step(0, i % 4, 15 - i, i % 4, (i / 4) % 4, i[0], "R5 idle");
    for (int i = 0; i < 16; i++) step(0, 0, 0, i % 4, i % 4, i[1], "R3 same");
    step(1, 2, 4'h9, 2, 2, 1, "R7 bypass");
    step(0, 0, 0, 2, 2, 1, "R7 after");
    for (int i = 0; i < 200; i++)
      step((i % 3) != 0, (i * 7) % 4, (i * 11 + 3) % 16, (i * 5) % 4, (i * 3 + 1) % 4, i[2], "R4 mix");
    rst = 1; @(posedge clk); #1; rst = 0;
    for (int i = 0; i < 4; i++) model[i] = 0;
    step(0, 0, 0, 1, 3, 1, "R1 rereset");
    step(0, 0, 0, 0, 2, 0, "R1 rereset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule